// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A request carries the virtual address and the translation-table base value. The walker reads one first-level descriptor. Depending on that descriptor it either finishes at once with a 1 MB section, or it reads a second-level descriptor from a coarse or fine table and finishes with a 64 KB, 4 KB or 1 KB page.

The result comes back as a one-cycle completion pulse. It carries the physical address, a page-size code, the cacheable/bufferable pair, the domain number and the access-permission field. An invalid descriptor at either level ends the walk with a fault instead.

The walker handles one request at a time and keeps one memory read outstanding. The memory read port is a request strobe plus a read-data valid strobe. A parameter controls whether fine second-level tables are supported.

Top module: `tbl_walker`

## Requirements
- R1: The first read of a walk goes to address {base[31:14], va[31:20], 2'b00}.
- R2: A first-level descriptor whose bits [1:0] equal 2'b10 ends the walk after one read as a section.
  - The physical address is {desc[31:20], va[19:0]} and the type code is 0.
  - Cacheable/bufferable is desc[3:2] and the permission field is desc[11:10], zero-extended to 8 bits.
- R3: A first-level descriptor whose bits [1:0] equal 2'b00 ends the walk after one read with a fault. On any fault, the address, type, cacheable/bufferable, domain and permission outputs read zero.
- R4: With FINE_EN = 0, a first-level descriptor whose bits [1:0] equal 2'b11 ends the walk after one read with a fault.
- R5: On every successful walk, the domain output equals first-level descriptor bits [8:5].
- R6: A first-level descriptor whose bits [1:0] equal 2'b01 (coarse table) causes a second read at {desc[31:10], va[19:12], 2'b00}.
- R7: With FINE_EN = 1, a first-level descriptor whose bits [1:0] equal 2'b11 (fine table) causes a second read at {desc[31:12], va[19:10], 2'b00}.
- R8: A second-level descriptor whose bits [1:0] equal 2'b00 ends the walk with a fault.
- R9: A second-level descriptor whose bits [1:0] equal 2'b01 gives a large page.
  - The physical address is {d2[31:16], va[15:0]} and the type code is 1.
  - The permission field is d2[11:4] and cacheable/bufferable is d2[3:2].
- R10: A second-level descriptor whose bits [1:0] equal 2'b10 gives a small page.
  - The physical address is {d2[31:12], va[11:0]} and the type code is 2.
  - The permission field is d2[11:4] and cacheable/bufferable is d2[3:2].
- R11: A second-level descriptor whose bits [1:0] equal 2'b11 gives a tiny page.
  - The physical address is {d2[31:10], va[9:0]} and the type code is 3.
  - The permission field is d2[5:4], zero-extended to 8 bits, and cacheable/bufferable is d2[3:2].
- R12: Handshake rules:
  - reqReady is high only while the walker is idle.
  - Each memory read is a single-cycle memReqValid strobe, and the next strobe is not raised until read data has returned.
  - doneValid is high for exactly one cycle, in the cycle after the last read data is accepted.
- R13: A synchronous active-high reset, including one applied in mid-walk, returns the walker to idle with reqReady high, memReqValid low and all done outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle and able to accept a request |
| reqVa | input | 32 | Virtual address to translate |
| reqBase | input | 32 | Translation-table base value |
| memReqValid | output | 1 | One-cycle memory read strobe |
| memAddr | output | 32 | Memory read word address |
| memRdValid | input | 1 | Read data valid strobe |
| memRdData | input | 32 | Read data (descriptor) |
| doneValid | output | 1 | One-cycle completion pulse |
| doneFault | output | 1 | Walk ended with a translation fault |
| donePa | output | 32 | Physical address |
| doneType | output | 2 | Page type: 0 section, 1 large, 2 small, 3 tiny |
| doneCb | output | 2 | Cacheable/bufferable bits |
| doneDomain | output | 4 | Domain number |
| doneAp | output | 8 | Access-permission field |

## Verification
The bench runs a sweep over every pairing of first-level and second-level descriptor kind. Each pairing is run with several virtual addresses, base values and descriptor payloads, and with memory latencies of zero to two cycles. This separates the address slices used for the coarse and fine table indices, and the page-size fields that large, small and tiny pages take from the second descriptor. Payloads differ from run to run, so a swapped or shifted bit field shows up in the physical address, permission or domain. A second instance with fine tables disabled receives the same stimulus, which shows the kind-3 first-level entry turning into a fault. A reset raised mid-walk checks that the walker returns to idle.

// File: rtl/walker_pkg.sv
package walker_pkg;
  localparam int ADDR_W = 32;
  localparam int KIND_W = 2;
  localparam int DOM_W  = 4;
  localparam int AP_W   = 8;
  localparam int CB_W   = 2;

  localparam logic [KIND_W-1:0] L1_FAULT  = 2'b00;
  localparam logic [KIND_W-1:0] L1_COARSE = 2'b01;
  localparam logic [KIND_W-1:0] L1_SECT   = 2'b10;
  localparam logic [KIND_W-1:0] L1_FINE   = 2'b11;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_TINY    = 2'd3
  } pgType_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_WT1, ST_RD2, ST_WT2
  } walkSt_e;

  typedef struct packed {
    logic loadReq;
    logic loadL1;
    logic finSect;
    logic finPage;
    logic fault;
    logic selL2;
  } walkCtl_t;
endpackage

// File: rtl/walker_ctrl.sv
module walker_ctrl
  import walker_pkg::*;
#(
  parameter bit FINE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  output logic              memReqValid,
  input  logic              memRdValid,
  input  logic [KIND_W-1:0] rdKind,
  output walkCtl_t          ctl
);
  walkSt_e stQ, stNxt;

  always_ff @(posedge clk) begin
    if (rst) stQ <= ST_IDLE;
    else     stQ <= stNxt;
  end

  always_comb begin
    stNxt = stQ;
    ctl   = '0;
    unique case (stQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadReq = 1'b1;
          stNxt       = ST_RD1;
        end
      end
      ST_RD1: stNxt = ST_WT1;
      ST_WT1: begin
        if (memRdValid) begin
          stNxt = ST_IDLE;
          unique case (rdKind)
            L1_FAULT:  ctl.fault   = 1'b1;
            L1_SECT:   ctl.finSect = 1'b1;
            L1_COARSE: begin
              ctl.loadL1 = 1'b1;
              stNxt      = ST_RD2;
            end
            default: begin
              if (FINE_EN) begin
                ctl.loadL1 = 1'b1;
                stNxt      = ST_RD2;
              end else begin
                ctl.fault = 1'b1;
              end
            end
          endcase
        end
      end
      ST_RD2: begin
        ctl.selL2 = 1'b1;
        stNxt     = ST_WT2;
      end
      ST_WT2: begin
        if (memRdValid) begin
          stNxt = ST_IDLE;
          if (rdKind == 2'b00) ctl.fault   = 1'b1;
          else                 ctl.finPage = 1'b1;
        end
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  assign reqReady    = (stQ == ST_IDLE);
  assign memReqValid = (stQ == ST_RD1) || (stQ == ST_RD2);
endmodule

// File: rtl/walker_dpath.sv
module walker_dpath
  import walker_pkg::*;
#(
  parameter bit FINE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  walkCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqVa,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              doneValid,
  output logic              doneFault,
  output logic [ADDR_W-1:0] donePa,
  output logic [1:0]        doneType,
  output logic [CB_W-1:0]   doneCb,
  output logic [DOM_W-1:0]  doneDomain,
  output logic [AP_W-1:0]   doneAp
);
  logic [ADDR_W-1:0] vaQ, baseQ, desc1Q;
  logic [ADDR_W-1:0] l1Addr, l2Addr, coarseAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      vaQ    <= '0;
      baseQ  <= '0;
      desc1Q <= '0;
    end else begin
      if (ctl.loadReq) begin
        vaQ   <= reqVa;
        baseQ <= reqBase;
      end
      if (ctl.loadL1) desc1Q <= memRdData;
    end
  end

  assign l1Addr     = {baseQ[31:14], vaQ[31:20], 2'b00};
  assign coarseAddr = {desc1Q[31:10], vaQ[19:12], 2'b00};

  generate
    if (FINE_EN) begin : g_fine
      logic [ADDR_W-1:0] fineAddr;
      assign fineAddr = {desc1Q[31:12], vaQ[19:10], 2'b00};
      assign l2Addr   = desc1Q[1] ? fineAddr : coarseAddr;
    end else begin : g_coarse
      assign l2Addr = coarseAddr;
    end
  endgenerate

  assign memAddr = ctl.selL2 ? l2Addr : l1Addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      doneValid  <= 1'b0;
      doneFault  <= 1'b0;
      donePa     <= '0;
      doneType   <= '0;
      doneCb     <= '0;
      doneDomain <= '0;
      doneAp     <= '0;
    end else begin
      doneValid <= ctl.fault | ctl.finSect | ctl.finPage;
      if (ctl.fault) begin
        doneFault  <= 1'b1;
        donePa     <= '0;
        doneType   <= '0;
        doneCb     <= '0;
        doneDomain <= '0;
        doneAp     <= '0;
      end else if (ctl.finSect) begin
        doneFault  <= 1'b0;
        donePa     <= {memRdData[31:20], vaQ[19:0]};
        doneType   <= PG_SECTION;
        doneCb     <= memRdData[3:2];
        doneDomain <= memRdData[8:5];
        doneAp     <= {6'b0, memRdData[11:10]};
      end else if (ctl.finPage) begin
        doneFault  <= 1'b0;
        doneCb     <= memRdData[3:2];
        doneDomain <= desc1Q[8:5];
        doneType   <= memRdData[1:0];
        unique case (memRdData[1:0])
          2'b01: begin
            donePa <= {memRdData[31:16], vaQ[15:0]};
            doneAp <= memRdData[11:4];
          end
          2'b10: begin
            donePa <= {memRdData[31:12], vaQ[11:0]};
            doneAp <= memRdData[11:4];
          end
          default: begin
            donePa <= {memRdData[31:10], vaQ[9:0]};
            doneAp <= {6'b0, memRdData[5:4]};
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
  import walker_pkg::*;
#(
  parameter bit FINE_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqVa,
  input  logic [31:0] reqBase,
  output logic        memReqValid,
  output logic [31:0] memAddr,
  input  logic        memRdValid,
  input  logic [31:0] memRdData,
  output logic        doneValid,
  output logic        doneFault,
  output logic [31:0] donePa,
  output logic [1:0]  doneType,
  output logic [1:0]  doneCb,
  output logic [3:0]  doneDomain,
  output logic [7:0]  doneAp
);
  walkCtl_t ctl;

  walker_ctrl #(.FINE_EN(FINE_EN)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .memRdValid(memRdValid),
    .rdKind(memRdData[KIND_W-1:0]), .ctl(ctl)
  );

  walker_dpath #(.FINE_EN(FINE_EN)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .reqVa(reqVa), .reqBase(reqBase),
    .memRdData(memRdData), .memAddr(memAddr), .doneValid(doneValid),
    .doneFault(doneFault), .donePa(donePa), .doneType(doneType),
    .doneCb(doneCb), .doneDomain(doneDomain), .doneAp(doneAp)
  );
endmodule

// File: rtl/walker_chk.sv
module walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqBase,
  input logic        memReqValid,
  input logic [31:0] memAddr,
  input logic        memRdValid,
  input logic [31:0] memRdData,
  input logic        doneValid,
  input logic        doneFault,
  input logic [31:0] donePa,
  input logic [1:0]  doneType,
  input logic [3:0]  doneDomain,
  input logic [7:0]  doneAp
);
  p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (rst)
    memReqValid |-> !reqReady);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> !doneValid);

  p_read_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    memReqValid |=> !memReqValid);

  p_l1_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (memReqValid && $past(reqValid && reqReady)) |->
      (memAddr[1:0] == 2'b00 && memAddr[31:14] == $past(reqBase[31:14])));

  p_section_one_read_r2: assert property (@(posedge clk) disable iff (rst)
    (doneValid && !doneFault && doneType == 2'd0) |->
      ($past(memRdValid) && $past(memRdData[1:0]) == 2'b10));

  p_fault_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (doneValid && doneFault) |->
      (donePa == 32'd0 && doneType == 2'd0 && doneDomain == 4'd0 && doneAp == 8'd0));

  p_tiny_ap_r11: assert property (@(posedge clk) disable iff (rst)
    (doneValid && !doneFault && doneType == 2'd3) |-> doneAp[7:2] == 6'd0);

  p_reset_idle_r13: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reqReady && !memReqValid && !doneValid && donePa == 32'd0));
endmodule

bind tbl_walker walker_chk u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .reqBase(reqBase), .memReqValid(memReqValid), .memAddr(memAddr),
  .memRdValid(memRdValid), .memRdData(memRdData), .doneValid(doneValid),
  .doneFault(doneFault), .donePa(donePa), .doneType(doneType),
  .doneDomain(doneDomain), .doneAp(doneAp)
);

// File: tb/tb_tbl_walker.sv
module tb_tbl_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0, reqBase = '0;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        reqReady, memReqValid, doneValid, doneFault;
  logic [31:0] memAddr, donePa;
  logic [1:0]  doneType, doneCb;
  logic [3:0]  doneDomain;
  logic [7:0]  doneAp;
  logic        nfReady, nfMemReq, nfDone, nfFault;
  logic [31:0] nfAddr, nfPa;
  logic [1:0]  nfType, nfCb;
  logic [3:0]  nfDom;
  logic [7:0]  nfAp;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tbl_walker #(.FINE_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .reqBase(reqBase), .memReqValid(memReqValid),
    .memAddr(memAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .doneValid(doneValid), .doneFault(doneFault), .donePa(donePa),
    .doneType(doneType), .doneCb(doneCb), .doneDomain(doneDomain), .doneAp(doneAp)
  );

  tbl_walker #(.FINE_EN(1'b0)) dutNf (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(nfReady),
    .reqVa(reqVa), .reqBase(reqBase), .memReqValid(nfMemReq),
    .memAddr(nfAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .doneValid(nfDone), .doneFault(nfFault), .donePa(nfPa),
    .doneType(nfType), .doneCb(nfCb), .doneDomain(nfDom), .doneAp(nfAp)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic waitFor(input bit useDone);
    int n = 0;
    while (!(useDone ? doneValid : memReqValid) && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic respond(input logic [31:0] d, input int lat);
    repeat (1 + lat) @(negedge clk);
    memRdValid = 1'b1;
    memRdData  = d;
    @(negedge clk);
    memRdValid = 1'b0;
    memRdData  = 32'hDEAD_BEEF;
  endtask

  task automatic runWalk(input logic [31:0] va, input logic [31:0] base,
                         input logic [31:0] d1, input logic [31:0] d2, input int lat);
    logic [31:0] expL1, expL2, expPa;
    logic [1:0]  expType, expCb;
    logic [3:0]  expDom;
    logic [7:0]  expAp;
    bit          twoLvl, expFault;
    string       rq;
    expL1 = {base[31:14], va[31:20], 2'b00};
    twoLvl = (d1[1:0] == 2'b01) || (d1[1:0] == 2'b11);
    expL2 = (d1[1:0] == 2'b01) ? {d1[31:10], va[19:12], 2'b00}
                               : {d1[31:12], va[19:10], 2'b00};
    expFault = 1'b0; expPa = '0; expType = '0; expCb = '0; expDom = '0; expAp = '0;
    case (d1[1:0])
      2'b00: begin expFault = 1'b1; rq = "R3"; end
      2'b10: begin
        rq = "R2"; expPa = {d1[31:20], va[19:0]}; expType = 2'd0;
        expCb = d1[3:2]; expDom = d1[8:5]; expAp = {6'b0, d1[11:10]};
      end
      default: begin
        expCb = d2[3:2]; expDom = d1[8:5];
        case (d2[1:0])
          2'b00: begin expFault = 1'b1; expCb = '0; expDom = '0; rq = "R8"; end
          2'b01: begin rq = "R9";  expType = 2'd1; expPa = {d2[31:16], va[15:0]}; expAp = d2[11:4]; end
          2'b10: begin rq = "R10"; expType = 2'd2; expPa = {d2[31:12], va[11:0]}; expAp = d2[11:4]; end
          default: begin rq = "R11"; expType = 2'd3; expPa = {d2[31:10], va[9:0]}; expAp = {6'b0, d2[5:4]}; end
        endcase
      end
    endcase

    @(negedge clk);
    chk(reqReady, "R12", "ready when idle", {31'b0, reqReady}, 32'd1);
    reqValid = 1'b1; reqVa = va; reqBase = base;
    @(negedge clk);
    reqValid = 1'b0;
    waitFor(1'b0);
    chk(memReqValid && memAddr == expL1, "R1", "level-1 read address", memAddr, expL1);
    chk(!reqReady, "R12", "not ready while walking", {31'b0, reqReady}, 32'd0);
    respond(d1, lat);
    if (d1[1:0] == 2'b11)
      chk(nfDone && nfFault, "R4", "fine entry faults when disabled",
          {30'b0, nfDone, nfFault}, 32'd3);
    if (twoLvl) begin
      waitFor(1'b0);
      chk(memReqValid && memAddr == expL2, d1[1] ? "R7" : "R6",
          "level-2 read address", memAddr, expL2);
      respond(d2, lat);
    end
    waitFor(1'b1);
    chk(doneValid, rq, "done pulse", {31'b0, doneValid}, 32'd1);
    chk(doneFault == expFault, rq, "fault flag", {31'b0, doneFault}, {31'b0, expFault});
    chk(donePa == expPa, rq, "physical address", donePa, expPa);
    chk(doneType == expType, rq, "page type", {30'b0, doneType}, {30'b0, expType});
    chk(doneCb == expCb, rq, "cacheable/bufferable", {30'b0, doneCb}, {30'b0, expCb});
    chk(doneDomain == expDom, "R5", "domain", {28'b0, doneDomain}, {28'b0, expDom});
    chk(doneAp == expAp, rq, "permission", {24'b0, doneAp}, {24'b0, expAp});
    @(negedge clk);
    chk(!doneValid, "R12", "done lasts one cycle", {31'b0, doneValid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady && !memReqValid && !doneValid, "R13", "reset state",
        {29'b0, reqReady, memReqValid, doneValid}, 32'd4);
    chk(donePa == 0 && doneAp == 0 && doneDomain == 0, "R13", "outputs cleared", donePa, 32'd0);
    rst = 1'b0;
    for (int k1 = 0; k1 < 4; k1++) begin
      for (int k2 = 0; k2 < 4; k2++) begin
        for (int j = 0; j < 3; j++) begin
          logic [31:0] va, base, d1, d2;
          va   = (32'h9E37_79B9 * (k1 * 12 + k2 * 3 + j + 1)) ^ 32'h5A5A_3C3C;
          base = 32'hC0DE_4000 ^ (32'h0F1E_2D3C * (j + 1));
          d1   = ((32'hA5C3_F1E0 ^ (32'h1357_9BDF * (k2 + 4 * j + 1))) & ~32'h3) | k1;
          d2   = ((32'h6B8D_2A40 ^ (32'h2468_ACE1 * (k1 + 4 * j + 3))) & ~32'h3) | k2;
          runWalk(va, base, d1, d2, j);
        end
      end
    end
    // R13: reset in mid-walk
    @(negedge clk);
    reqValid = 1'b1; reqVa = 32'h1234_5678; reqBase = 32'h0004_0000;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(reqReady && !memReqValid && !doneValid, "R13", "mid-walk reset to idle",
        {29'b0, reqReady, memReqValid, doneValid}, 32'd4);
    runWalk(32'h0010_0ABC, 32'h8000_0000, 32'h7650_0C0E, 32'h0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule